// File: doc/BRIEF.md
# Flash command interface decoder

This block is the command front end of a parallel NOR flash device. It watches bus write cycles, each one carrying an address and a command or data byte. It recognises one-cycle commands, which change the read mode or fire a single-clock request. It also recognises two-cycle sequences, which are a setup write followed by a confirm or data write. The read mode tells the read path which source answers a bus read: the memory array, the identifier space, the status register or the query table. Block erase, program, suspend, resume and status-clear requests go to an external array controller as one-clock pulses, together with the latched address and data.

The block also owns a 16-bit burst configuration register. The value is taken from the low address bits of the confirm write, not from the data bus. After the register loads, the read mode returns to array read without a further command. Reads in identifier mode return a manufacturer byte, a device byte or the configuration register, selected by the read offset.

Top module: `flash_cmd_decoder`

## Requirements
- R1: Reset is synchronous and active-low. It sets the read mode to array (encoding 0), clears the configuration register to 0000h, holds every request pulse low and discards any partly entered sequence.
- R2: A single write of FFh, 90h, 70h or 98h, at any address, sets the read mode to array (0), identifier (1), status (2) or query (3) respectively.
- R3: `ident_data` presents the manufacturer code (default 0020h) at read offset 0, the device code (default 0041h) at offset 1, the configuration register at offset 5, and 0000h at every other offset.
- R4: A single write with an unrecognised code leaves the read mode unchanged and raises no pulse.
- R5: A write of 50h raises `clr_status_go` for one cycle and leaves the read mode unchanged.
- R6: When no sequence is pending, a write of B0h raises `suspend_go` and a write of D0h raises `resume_go`, each for one cycle, and the read mode is left unchanged.
- R7: A write of 20h followed by a write of D0h raises `erase_go` for one cycle. `erase_addr` holds the address of the second write, and the read mode becomes status.
- R8: A write of 40h or 10h makes the next write the program data, whatever its value. That write raises `prog_go` for one cycle with `prog_addr` and `prog_data` taken from it, and the read mode becomes status.
- R9: A write of 60h followed by a write of 03h loads the configuration register from address bits 15..0 of the second write, ignoring higher bits. It raises `cfg_go` for one cycle and sets the read mode to array. At no other time does the register change, except at reset.
- R10: If the second write of an erase or configuration sequence carries a wrong confirm code, `seq_err` pulses for one cycle and no operation starts. The read mode becomes status, the register keeps its value, and the next write is decoded as a new command.
- R11: At most one request pulse is high in any cycle. Each pulse appears in the cycle after its write edge and drops after one cycle unless a further write raises it again.
- R12: A reset that arrives between the setup write and the confirm write cancels the sequence. A following confirm code is treated as a single-cycle write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Bus write cycle strobe, one clock per write |
| wr_addr | input | 20 | Write address |
| wr_data | input | 8 | Write data / command byte |
| rd_addr | input | 20 | Read offset for identifier space |
| rd_mode | output | 2 | Read mode: 0 array, 1 identifier, 2 status, 3 query |
| ident_data | output | 16 | Identifier space read value |
| bcr | output | 16 | Burst configuration register |
| erase_go | output | 1 | Block erase start pulse |
| erase_addr | output | 20 | Address inside the block to erase |
| prog_go | output | 1 | Program start pulse |
| prog_addr | output | 20 | Program address |
| prog_data | output | 8 | Program data |
| suspend_go | output | 1 | Suspend request pulse |
| resume_go | output | 1 | Resume request pulse |
| clr_status_go | output | 1 | Clear status request pulse |
| cfg_go | output | 1 | Configuration register loaded pulse |
| seq_err | output | 1 | Bad confirm code pulse, for the status register |

## Verification
The bench writes FFh as program data to show that a pending program sequence does not let it act as the array-read command. A decoder that checks opcodes before it checks the pending state would switch to array read and drop the program. It writes D0h both alone and as an erase confirm, because a design that mixes up these two cases issues a resume in place of an erase, or the reverse. The configuration load is driven with address bits above bit 15 set and with a wrong confirm code. A design that takes the data bus or the wide address would show a wrong register value, and one that does not abort would either load the register or stay stuck in the sequence. A reset between setup and confirm tests that the pending state is cleared, since a design that keeps it would load the register from the following 03h write.

// File: rtl/fcd_pkg.sv
// Shared types for the flash command decoder.
// Assumes command bytes sit in the low eight bits of the write data bus.
package fcd_pkg;

    typedef enum logic [1:0] {
        RD_ARRAY  = 2'd0,
        RD_IDENT  = 2'd1,
        RD_STATUS = 2'd2,
        RD_QUERY  = 2'd3
    } rd_mode_t;

    typedef enum logic [3:0] {
        OP_NONE,
        OP_ARRAY,
        OP_IDENT,
        OP_STATUS,
        OP_QUERY,
        OP_CLEAR,
        OP_ERASE_SETUP,
        OP_PROG_SETUP,
        OP_CFG_SETUP,
        OP_SUSPEND,
        OP_RESUME
    } op_t;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_ERASE,
        SQ_PROG,
        SQ_CFG
    } seq_t;

    localparam logic [7:0] CODE_ARRAY   = 8'hFF;
    localparam logic [7:0] CODE_IDENT   = 8'h90;
    localparam logic [7:0] CODE_STATUS  = 8'h70;
    localparam logic [7:0] CODE_QUERY   = 8'h98;
    localparam logic [7:0] CODE_CLEAR   = 8'h50;
    localparam logic [7:0] CODE_ERASE   = 8'h20;
    localparam logic [7:0] CODE_PROG_A  = 8'h40;
    localparam logic [7:0] CODE_PROG_B  = 8'h10;
    localparam logic [7:0] CODE_SUSPEND = 8'hB0;
    localparam logic [7:0] CODE_CONFIRM = 8'hD0;
    localparam logic [7:0] CODE_CFG     = 8'h60;
    localparam logic [7:0] CODE_CFG_OK  = 8'h03;

endpackage

// File: rtl/fcd_op_decode.sv
// Classifies a command byte into a one-cycle opcode.
// Pure combinational; the sequence controller decides whether the result
// applies (it does not when a second write is pending).
module fcd_op_decode
    import fcd_pkg::*;
(
    input  logic [7:0] cmd_byte,
    output op_t        op
);

    // Map each recognised byte to its opcode, everything else to OP_NONE.
    always_comb begin
        unique case (cmd_byte)
            CODE_ARRAY:              op = OP_ARRAY;
            CODE_IDENT:              op = OP_IDENT;
            CODE_STATUS:             op = OP_STATUS;
            CODE_QUERY:              op = OP_QUERY;
            CODE_CLEAR:              op = OP_CLEAR;
            CODE_ERASE:              op = OP_ERASE_SETUP;
            CODE_PROG_A, CODE_PROG_B: op = OP_PROG_SETUP;
            CODE_CFG:                op = OP_CFG_SETUP;
            CODE_SUSPEND:            op = OP_SUSPEND;
            CODE_CONFIRM:            op = OP_RESUME;
            default:                 op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/fcd_seq_ctrl.sv
// Sequence controller: holds the pending two-cycle state and the read mode,
// and produces the registered one-clock request pulses.
// Assumes wr_en is high for exactly one clock per bus write.
module fcd_seq_ctrl
    import fcd_pkg::*;
#(
    parameter int ADDR_W = 20,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  op_t               op,
    output rd_mode_t          mode,
    output logic              cfg_load,
    output logic              erase_go,
    output logic              prog_go,
    output logic              cfg_go,
    output logic              suspend_go,
    output logic              resume_go,
    output logic              clr_go,
    output logic              seq_err,
    output logic [ADDR_W-1:0] op_addr,
    output logic [DATA_W-1:0] op_data
);

    seq_t state;
    logic [7:0] cmd_low;

    assign cmd_low = wr_data[7:0];

    // Early load strobe so the register updates on the same edge as cfg_go.
    assign cfg_load = wr_en && (state == SQ_CFG) && (cmd_low == CODE_CFG_OK);

    // Advance the sequence, update the read mode and issue request pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state      <= SQ_IDLE;
            mode       <= RD_ARRAY;
            erase_go   <= 1'b0;
            prog_go    <= 1'b0;
            cfg_go     <= 1'b0;
            suspend_go <= 1'b0;
            resume_go  <= 1'b0;
            clr_go     <= 1'b0;
            seq_err    <= 1'b0;
            op_addr    <= '0;
            op_data    <= '0;
        end else begin
            erase_go   <= 1'b0;
            prog_go    <= 1'b0;
            cfg_go     <= 1'b0;
            suspend_go <= 1'b0;
            resume_go  <= 1'b0;
            clr_go     <= 1'b0;
            seq_err    <= 1'b0;
            if (wr_en) begin
                case (state)
                    SQ_IDLE: begin
                        case (op)
                            OP_ARRAY:       mode <= RD_ARRAY;
                            OP_IDENT:       mode <= RD_IDENT;
                            OP_STATUS:      mode <= RD_STATUS;
                            OP_QUERY:       mode <= RD_QUERY;
                            OP_CLEAR:       clr_go <= 1'b1;
                            OP_SUSPEND:     suspend_go <= 1'b1;
                            OP_RESUME:      resume_go <= 1'b1;
                            OP_ERASE_SETUP: state <= SQ_ERASE;
                            OP_PROG_SETUP:  state <= SQ_PROG;
                            OP_CFG_SETUP:   state <= SQ_CFG;
                            default:        ;
                        endcase
                    end
                    SQ_ERASE: begin
                        state <= SQ_IDLE;
                        mode  <= RD_STATUS;
                        if (cmd_low == CODE_CONFIRM) begin
                            erase_go <= 1'b1;
                            op_addr  <= wr_addr;
                        end else begin
                            seq_err <= 1'b1;
                        end
                    end
                    SQ_PROG: begin
                        state   <= SQ_IDLE;
                        mode    <= RD_STATUS;
                        prog_go <= 1'b1;
                        op_addr <= wr_addr;
                        op_data <= wr_data;
                    end
                    default: begin
                        state <= SQ_IDLE;
                        if (cmd_low == CODE_CFG_OK) begin
                            cfg_go <= 1'b1;
                            mode   <= RD_ARRAY;
                        end else begin
                            seq_err <= 1'b1;
                            mode    <= RD_STATUS;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/fcd_cfg_reg.sv
// Burst configuration register. Loads from the low address bits when the
// controller signals a valid confirm; otherwise holds.
// Assumes ADDR_W >= CFG_W.
module fcd_cfg_reg #(
    parameter int ADDR_W = 20,
    parameter int CFG_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] addr,
    output logic [CFG_W-1:0]  value
);

    // Capture the register image from the address bus on a confirmed load.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= addr[CFG_W-1:0];
        end
    end

endmodule

// File: rtl/fcd_ident_mux.sv
// Identifier space read mux: returns the manufacturer code, device code or
// configuration register by read offset. Not gated by read mode; the read
// path selects it when the mode is identifier.
module fcd_ident_mux #(
    parameter int         ADDR_W   = 20,
    parameter int         CFG_W    = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h41
) (
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CFG_W-1:0]  cfg_value,
    output logic [CFG_W-1:0]  rd_value
);

    localparam logic [ADDR_W-1:0] OFS_MFR = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_DEV = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] OFS_CFG = ADDR_W'(5);

    // Select the identifier word for the current read offset.
    always_comb begin
        if (rd_addr == OFS_MFR)      rd_value = CFG_W'(MFR_CODE);
        else if (rd_addr == OFS_DEV) rd_value = CFG_W'(DEV_CODE);
        else if (rd_addr == OFS_CFG) rd_value = cfg_value;
        else                         rd_value = '0;
    end

endmodule

// File: rtl/flash_cmd_decoder.sv
// Top of the flash command decoder: classifies bus writes, runs one- and
// two-cycle command sequences, holds the burst configuration register and
// serves identifier reads. Assumes one clock of wr_en per bus write.
module flash_cmd_decoder
    import fcd_pkg::*;
#(
    parameter int         ADDR_W   = 20,
    parameter int         DATA_W   = 8,
    parameter int         CFG_W    = 16,
    parameter logic [7:0] MFR_CODE = 8'h20,
    parameter logic [7:0] DEV_CODE = 8'h41
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [1:0]        rd_mode,
    output logic [CFG_W-1:0]  ident_data,
    output logic [CFG_W-1:0]  bcr,
    output logic              erase_go,
    output logic [ADDR_W-1:0] erase_addr,
    output logic              prog_go,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data,
    output logic              suspend_go,
    output logic              resume_go,
    output logic              clr_status_go,
    output logic              cfg_go,
    output logic              seq_err
);

    op_t               op;
    rd_mode_t          mode;
    logic              cfg_load;
    logic [ADDR_W-1:0] op_addr;

    fcd_op_decode u_decode (
        .cmd_byte (wr_data[7:0]),
        .op       (op)
    );

    fcd_seq_ctrl #(
        .ADDR_W (ADDR_W),
        .DATA_W (DATA_W)
    ) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .op         (op),
        .mode       (mode),
        .cfg_load   (cfg_load),
        .erase_go   (erase_go),
        .prog_go    (prog_go),
        .cfg_go     (cfg_go),
        .suspend_go (suspend_go),
        .resume_go  (resume_go),
        .clr_go     (clr_status_go),
        .seq_err    (seq_err),
        .op_addr    (op_addr),
        .op_data    (prog_data)
    );

    fcd_cfg_reg #(
        .ADDR_W (ADDR_W),
        .CFG_W  (CFG_W)
    ) u_cfg (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (cfg_load),
        .addr  (wr_addr),
        .value (bcr)
    );

    fcd_ident_mux #(
        .ADDR_W   (ADDR_W),
        .CFG_W    (CFG_W),
        .MFR_CODE (MFR_CODE),
        .DEV_CODE (DEV_CODE)
    ) u_ident (
        .rd_addr   (rd_addr),
        .cfg_value (bcr),
        .rd_value  (ident_data)
    );

    assign rd_mode    = mode;
    assign erase_addr = op_addr;
    assign prog_addr  = op_addr;

endmodule

// File: rtl/fcd_checker.sv
// Protocol checker for flash_cmd_decoder, attached by bind below.
module fcd_checker #(
    parameter int CFG_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [1:0]       rd_mode,
    input logic [CFG_W-1:0] bcr,
    input logic             erase_go,
    input logic             prog_go,
    input logic             cfg_go,
    input logic             suspend_go,
    input logic             resume_go,
    input logic             clr_status_go,
    input logic             seq_err
);

    logic [6:0] pulses;
    assign pulses = {erase_go, prog_go, cfg_go, suspend_go, resume_go, clr_status_go, seq_err};

    assert_one_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(pulses));

    assert_pulse_after_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (|pulses) |-> $past(wr_en));

    assert_pulse_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((|pulses) && !wr_en) |=> (pulses == 7'd0));

    assert_erase_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        erase_go |-> (rd_mode == 2'd2));

    assert_prog_status_R8: assert property (@(posedge clk) disable iff (!rst_n)
        prog_go |-> (rd_mode == 2'd2));

    assert_cfg_array_R9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_go |-> (rd_mode == 2'd0));

    assert_bcr_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !cfg_go) |-> $stable(bcr));

    assert_err_status_R10: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> (rd_mode == 2'd2));

    assert_clear_keeps_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && clr_status_go) |-> $stable(rd_mode));

    assert_susp_res_keeps_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && (suspend_go || resume_go)) |-> $stable(rd_mode));

endmodule

bind flash_cmd_decoder fcd_checker #(.CFG_W(CFG_W)) chk_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .wr_en         (wr_en),
    .rd_mode       (rd_mode),
    .bcr           (bcr),
    .erase_go      (erase_go),
    .prog_go       (prog_go),
    .cfg_go        (cfg_go),
    .suspend_go    (suspend_go),
    .resume_go     (resume_go),
    .clr_status_go (clr_status_go),
    .seq_err       (seq_err)
);

// File: tb/flash_cmd_decoder_tb_top.sv
`timescale 1ns/1ps
module flash_cmd_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [19:0] wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [19:0] rd_addr = '0;
    logic [1:0]  rd_mode;
    logic [15:0] ident_data, bcr;
    logic        erase_go, prog_go, suspend_go, resume_go, clr_status_go, cfg_go, seq_err;
    logic [19:0] erase_addr, prog_addr;
    logic [7:0]  prog_data;
    logic [6:0]  pulses;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    flash_cmd_decoder dut_i (
        .clk (clk), .rst_n (rst_n), .wr_en (wr_en), .wr_addr (wr_addr),
        .wr_data (wr_data), .rd_addr (rd_addr), .rd_mode (rd_mode),
        .ident_data (ident_data), .bcr (bcr), .erase_go (erase_go),
        .erase_addr (erase_addr), .prog_go (prog_go), .prog_addr (prog_addr),
        .prog_data (prog_data), .suspend_go (suspend_go), .resume_go (resume_go),
        .clr_status_go (clr_status_go), .cfg_go (cfg_go), .seq_err (seq_err)
    );

    assign pulses = {erase_go, prog_go, cfg_go, suspend_go, resume_go, clr_status_go, seq_err};

    // Pulse order: erase, prog, cfg, suspend, resume, clear, error
    localparam logic [6:0] P0  = 7'b0000000;
    localparam logic [6:0] PER = 7'b1000000;
    localparam logic [6:0] PPG = 7'b0100000;
    localparam logic [6:0] PCF = 7'b0010000;
    localparam logic [6:0] PSU = 7'b0001000;
    localparam logic [6:0] PRS = 7'b0000100;
    localparam logic [6:0] PCL = 7'b0000010;
    localparam logic [6:0] PEE = 7'b0000001;

    function automatic logic [56:0] vec(input logic [19:0] a, input logic [7:0] d,
                                        input logic [1:0] m, input logic [6:0] p,
                                        input logic [15:0] b, input logic [3:0] r);
        return {a, d, m, p, b, r};
    endfunction

    localparam int NV = 22;
    localparam logic [56:0] VECS [NV] = '{
        vec(20'h00000, 8'hFF, 2'd0, P0,  16'h0000, 4'd2),  // R2 array
        vec(20'h11111, 8'h90, 2'd1, P0,  16'h0000, 4'd2),  // R2 ident
        vec(20'h22222, 8'h70, 2'd2, P0,  16'h0000, 4'd2),  // R2 status
        vec(20'h33333, 8'h98, 2'd3, P0,  16'h0000, 4'd2),  // R2 query
        vec(20'h00000, 8'h55, 2'd3, P0,  16'h0000, 4'd4),  // R4 unknown code
        vec(20'h44444, 8'h50, 2'd3, PCL, 16'h0000, 4'd5),  // R5 clear
        vec(20'h00000, 8'hB0, 2'd3, PSU, 16'h0000, 4'd6),  // R6 suspend
        vec(20'h00000, 8'hD0, 2'd3, PRS, 16'h0000, 4'd6),  // R6 resume
        vec(20'h12345, 8'h20, 2'd3, P0,  16'h0000, 4'd7),  // R7 erase setup
        vec(20'h40000, 8'hD0, 2'd2, PER, 16'h0000, 4'd7),  // R7 erase confirm
        vec(20'h00000, 8'h40, 2'd2, P0,  16'h0000, 4'd8),  // R8 program setup
        vec(20'h00AAA, 8'hFF, 2'd2, PPG, 16'h0000, 4'd8),  // R8 FF as data
        vec(20'h00000, 8'h10, 2'd2, P0,  16'h0000, 4'd8),  // R8 alt setup
        vec(20'h00123, 8'h3C, 2'd2, PPG, 16'h0000, 4'd8),  // R8 data
        vec(20'hFABCD, 8'h60, 2'd2, P0,  16'h0000, 4'd9),  // R9 cfg setup
        vec(20'hFABCD, 8'h03, 2'd0, PCF, 16'hABCD, 4'd9),  // R9 load, high bits dropped
        vec(20'h01111, 8'h60, 2'd0, P0,  16'hABCD, 4'd10), // R10 cfg setup
        vec(20'h01111, 8'hFF, 2'd2, PEE, 16'hABCD, 4'd10), // R10 bad confirm
        vec(20'h00000, 8'hFF, 2'd0, P0,  16'hABCD, 4'd10), // R10 recovers
        vec(20'h00000, 8'h20, 2'd0, P0,  16'hABCD, 4'd10), // R10 erase setup
        vec(20'h00000, 8'h50, 2'd2, PEE, 16'hABCD, 4'd10), // R10 bad erase confirm
        vec(20'h00000, 8'h90, 2'd1, P0,  16'hABCD, 4'd10)  // R10 normal decode
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // One bus write; returns at the negedge after the capturing edge.
    task automatic bus_write(input logic [19:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1;
        wr_addr = a;
        wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "mode", 32'(rd_mode), 32'd0);
        check("R1", "bcr", 32'(bcr), 32'h0);
        check("R1", "pulses", 32'(pulses), 32'h0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", VECS[i][3:0]);
            bus_write(VECS[i][56:37], VECS[i][36:29]);
            check(rq, $sformatf("vec %0d mode", i), 32'(rd_mode), 32'(VECS[i][28:27]));
            check(rq, $sformatf("vec %0d pulses", i), 32'(pulses), 32'(VECS[i][26:20]));
            check(rq, $sformatf("vec %0d bcr", i), 32'(bcr), 32'(VECS[i][19:4]));
            @(negedge clk);
            // R11 pulse lasts one cycle
            check("R11", $sformatf("vec %0d idle pulses", i), 32'(pulses), 32'h0);
        end

        // R3 identifier reads, bcr now ABCDh
        rd_addr = 20'd0; #1;
        check("R3", "mfr", 32'(ident_data), 32'h0020);
        rd_addr = 20'd1; #1;
        check("R3", "dev", 32'(ident_data), 32'h0041);
        rd_addr = 20'd5; #1;
        check("R3", "cfg", 32'(ident_data), 32'hABCD);
        rd_addr = 20'd2; #1;
        check("R3", "other", 32'(ident_data), 32'h0000);

        // R7 erase address comes from the confirm write
        bus_write(20'h00001, 8'h20);
        bus_write(20'h32100, 8'hD0);
        check("R7", "erase_go", 32'(erase_go), 32'd1);
        check("R7", "erase_addr", 32'(erase_addr), 32'h32100);

        // R8 program address and data
        bus_write(20'h00000, 8'h40);
        bus_write(20'h0BEEF, 8'h5A);
        check("R8", "prog_go", 32'(prog_go), 32'd1);
        check("R8", "prog_addr", 32'(prog_addr), 32'h0BEEF);
        check("R8", "prog_data", 32'(prog_data), 32'h5A);

        // R12 reset between setup and confirm
        bus_write(20'h05555, 8'h60);
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check("R1", "mode after reset", 32'(rd_mode), 32'd0);
        check("R1", "bcr after reset", 32'(bcr), 32'h0);
        bus_write(20'h07777, 8'h03);
        check("R12", "no cfg pulse", 32'(pulses), 32'h0);
        check("R12", "bcr unchanged", 32'(bcr), 32'h0);
        check("R12", "mode unchanged", 32'(rd_mode), 32'd0);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule